// File: doc/BRIEF.md
# Two-Phase Access-Configuration Capture Latch

This block sits between a processor's register-access decode and a set of programmable memory-access ports. Software builds a 32-bit access-control word by making two 16-bit accesses to a single control location. The first access handles the upper half, which is the address part. The second handles the lower half, which is the mode part. Once the second half is taken, the latch is armed. The next access to any of the access registers does not move data. Instead it files the control word as that register's configuration, in a read slot when the access is a read and in a write slot when it is a write.

Once a register has a nonzero configuration for the direction in use, further accesses in that direction count as programmed-mode traffic. They return zero and raise a mode indication, and the transfer engine downstream is expected to act on it. A register with no configuration for that direction behaves as an ordinary 16-bit storage register. If a second control word is completed before the first one was used, a one-cycle anomaly pulse is raised.

Top module: `macc_cfg_latch`

## Requirements
- R1: After reset, the half-select points at the upper half, the latch is not armed, every read and write configuration slot is zero, every plain register is zero, `anomaly` is low and `ctl_rdata` is 0.
- R2: Each control access (`ctl_wr` or `ctl_rd`) toggles the half-select. A control write loads `ctl_wdata` into the upper half (bits 31:16) when the half-select is upper, and into the lower half (bits 15:0) when it is lower. After the lower half has been taken, the half-select returns to the upper half.
- R3: A control read advances the half-select exactly as a write does, without changing either half. `ctl_rdata` always shows the half that the next control access will select.
- R4: A control access that takes the lower half arms the latch. While the latch is armed, a register read at index n < 5 stores the current 32-bit word into read slot n (`rd_cfg[32n+31:32n]`), returns 0, and clears the armed flag.
- R5: While the latch is armed, a register write at index n < 5 stores the word into write slot n (`wr_cfg[32n+31:32n]`), clears the armed flag, and loads no plain register. Every other slot keeps its value.
- R6: Taking the lower half while the latch is already armed raises `anomaly` for exactly one cycle, in the cycle after that access.
- R7: When the latch is not armed and the slot for the access's direction and index is nonzero, the access returns 0 and `mode_active` is high during it. A write of this kind leaves the plain register unchanged.
- R8: When the latch is not armed and the slot is zero, a read returns the plain register at that index and a write loads it. `mode_active` stays low.
- R9: Register accesses with an index of 5 or more return 0, leave `mode_active` low, and change neither the slots nor the armed flag.
- R10: A control strobe takes priority over any register strobe in the same cycle, and that register access is dropped. When `reg_wr` and `reg_rd` are both high, the access is handled as a write.
- R11: Read and write slots are independent. Configuring one direction of a register leaves accesses in the other direction on their own slot (a plain access while that slot is zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_rd | input | 1 | Read strobe on the control location |
| ctl_wr | input | 1 | Write strobe on the control location |
| ctl_wdata | input | 16 | Control write data |
| ctl_rdata | output | 16 | Half of the control word selected next |
| reg_rd | input | 1 | Read strobe on an access register |
| reg_wr | input | 1 | Write strobe on an access register |
| reg_idx | input | 3 | Access register index |
| reg_wdata | input | 16 | Access register write data |
| reg_rdata | output | 16 | Access register read data |
| mode_active | output | 1 | Current access hits a configured slot |
| anomaly | output | 1 | Pulse: unconsumed control word overwritten |
| rd_cfg | output | 160 | Five read-slot configurations, slot n at bits 32n+31:32n |
| wr_cfg | output | 160 | Five write-slot configurations, slot n at bits 32n+31:32n |

## Verification
The plain path is first swept across all five indices, with distinct values for writes and readbacks. Every index is then configured in both directions: write captures are built from two control writes, and read captures are built from a control write plus a control read, so the mixed word shows that reads advance the half without loading it. After each capture, the other direction of the same register is accessed to confirm it still falls through to plain storage, and a repeat access confirms programmed mode. Further sequences cover out-of-range indices while armed, back-to-back completed words, and same-cycle strobe collisions. These separate the anomaly, ignore and priority rules from ordinary capture.

// File: rtl/macc_cfg_pkg.sv
package macc_cfg_pkg;

   typedef enum logic [2:0] {
      K_IDLE    = 3'd0,
      K_CTL     = 3'd1,
      K_CAPTURE = 3'd2,
      K_PROG    = 3'd3,
      K_PLAIN   = 3'd4
   } acc_kind_e;

   function automatic acc_kind_e classify(input logic ctl_go,
                                          input logic reg_ok,
                                          input logic armed,
                                          input logic slot_hit);
      acc_kind_e k;
      if (ctl_go)        k = K_CTL;
      else if (!reg_ok)  k = K_IDLE;
      else if (armed)    k = K_CAPTURE;
      else if (slot_hit) k = K_PROG;
      else               k = K_PLAIN;
      return k;
   endfunction

endpackage

// File: rtl/macc_ctl_seq.sv
module macc_ctl_seq #(
   parameter int DW = 16,
   localparam int CW = 2 * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_go,
   input  logic          ctl_load,
   input  logic [DW-1:0] ctl_wdata,
   input  logic          consume,
   output logic          half_q,
   output logic          armed_q,
   output logic          anomaly_q,
   output logic [CW-1:0] word,
   output logic [DW-1:0] sel_data
);

   logic [DW-1:0] upper_q;
   logic [DW-1:0] lower_q;
   logic          finish;

   assign finish   = ctl_go && half_q;
   assign word     = {upper_q, lower_q};
   assign sel_data = half_q ? lower_q : upper_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         half_q    <= 1'b0;
         armed_q   <= 1'b0;
         anomaly_q <= 1'b0;
         upper_q   <= '0;
         lower_q   <= '0;
      end else begin
         anomaly_q <= finish && armed_q;
         if (ctl_go) half_q <= ~half_q;
         if (ctl_load && !half_q) upper_q <= ctl_wdata;
         if (ctl_load && half_q)  lower_q <= ctl_wdata;
         if (finish)       armed_q <= 1'b1;
         else if (consume) armed_q <= 1'b0;
      end
   end

endmodule

// File: rtl/macc_slot_bank.sv
module macc_slot_bank #(
   parameter int NREG = 5,
   parameter int IDXW = 3,
   parameter int CW   = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_en,
   input  logic               cap_wr,
   input  logic [IDXW-1:0]    idx,
   input  logic [CW-1:0]      word,
   output logic [NREG*CW-1:0] rd_bus,
   output logic [NREG*CW-1:0] wr_bus,
   output logic               rd_hit,
   output logic               wr_hit
);

   logic [CW-1:0] rd_slot [NREG];
   logic [CW-1:0] wr_slot [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_slot
      logic sel;
      assign sel = (idx == IDXW'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_slot[g] <= '0;
            wr_slot[g] <= '0;
         end else if (cap_en && sel) begin
            if (cap_wr) wr_slot[g] <= word;
            else        rd_slot[g] <= word;
         end
      end
      assign rd_bus[g*CW +: CW] = rd_slot[g];
      assign wr_bus[g*CW +: CW] = wr_slot[g];
   end

   always_comb begin
      rd_hit = 1'b0;
      wr_hit = 1'b0;
      for (int i = 0; i < NREG; i++) begin
         if (idx == IDXW'(i)) begin
            rd_hit = |rd_slot[i];
            wr_hit = |wr_slot[i];
         end
      end
   end

endmodule

// File: rtl/macc_plain_bank.sv
module macc_plain_bank #(
   parameter int DW     = 16,
   parameter int NREG   = 5,
   parameter int IDXW   = 3,
   parameter bit SHARED = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld,
   input  logic [IDXW-1:0] idx,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rdata
);

   if (SHARED) begin : g_shared
      logic [DW-1:0] one_q;
      always_ff @(posedge clk) begin
         if (!rst_n)  one_q <= '0;
         else if (ld) one_q <= wdata;
      end
      assign rdata = one_q;
   end else begin : g_split
      logic [DW-1:0] bank_q [NREG];
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) bank_q[g] <= '0;
            else if (ld && (idx == IDXW'(g))) bank_q[g] <= wdata;
         end
      end
      always_comb begin
         rdata = '0;
         for (int i = 0; i < NREG; i++)
            if (idx == IDXW'(i)) rdata = bank_q[i];
      end
   end

endmodule

// File: rtl/macc_cfg_latch.sv
module macc_cfg_latch
   import macc_cfg_pkg::*;
#(
   parameter int DW           = 16,
   parameter int NREG         = 5,
   parameter int IDXW         = 3,
   parameter bit SHARED_PLAIN = 1'b0,
   localparam int CW = 2 * DW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_rd,
   input  logic               ctl_wr,
   input  logic [DW-1:0]      ctl_wdata,
   output logic [DW-1:0]      ctl_rdata,
   input  logic               reg_rd,
   input  logic               reg_wr,
   input  logic [IDXW-1:0]    reg_idx,
   input  logic [DW-1:0]      reg_wdata,
   output logic [DW-1:0]      reg_rdata,
   output logic               mode_active,
   output logic               anomaly,
   output logic [NREG*CW-1:0] rd_cfg,
   output logic [NREG*CW-1:0] wr_cfg
);

   localparam logic [IDXW:0] NREG_L = NREG[IDXW:0];

   if (DW < 1) begin : g_bad_dw
      $error("DW must be at least 1");
   end
   if (NREG < 1 || NREG > (1 << IDXW)) begin : g_bad_nreg
      $error("NREG must fit in IDXW index bits");
   end

   logic          ctl_go;
   logic          reg_ok;
   logic          is_wr;
   logic          half_q;
   logic          armed_q;
   logic [CW-1:0] ctl_word;
   logic          rd_hit;
   logic          wr_hit;
   logic [DW-1:0] plain_val;
   acc_kind_e     kind;

   assign ctl_go = ctl_rd | ctl_wr;
   assign reg_ok = (reg_rd | reg_wr) && ({1'b0, reg_idx} < NREG_L);
   assign is_wr  = reg_wr;
   assign kind   = classify(ctl_go, reg_ok, armed_q, is_wr ? wr_hit : rd_hit);

   macc_ctl_seq #(.DW(DW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_go    (ctl_go),
      .ctl_load  (ctl_wr),
      .ctl_wdata (ctl_wdata),
      .consume   (kind == K_CAPTURE),
      .half_q    (half_q),
      .armed_q   (armed_q),
      .anomaly_q (anomaly),
      .word      (ctl_word),
      .sel_data  (ctl_rdata)
   );

   macc_slot_bank #(.NREG(NREG), .IDXW(IDXW), .CW(CW)) u_slots (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (kind == K_CAPTURE),
      .cap_wr (is_wr),
      .idx    (reg_idx),
      .word   (ctl_word),
      .rd_bus (rd_cfg),
      .wr_bus (wr_cfg),
      .rd_hit (rd_hit),
      .wr_hit (wr_hit)
   );

   macc_plain_bank #(.DW(DW), .NREG(NREG), .IDXW(IDXW), .SHARED(SHARED_PLAIN)) u_plain (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    ((kind == K_PLAIN) && is_wr),
      .idx   (reg_idx),
      .wdata (reg_wdata),
      .rdata (plain_val)
   );

   assign mode_active = (kind == K_PROG);
   assign reg_rdata   = ((kind == K_PLAIN) && !is_wr) ? plain_val : '0;

endmodule

// File: rtl/macc_cfg_latch_chk.sv
module macc_cfg_latch_chk #(
   parameter int DW   = 16,
   parameter int NREG = 5,
   parameter int IDXW = 3,
   localparam int CW  = 2 * DW
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ctl_rd,
   input logic               ctl_wr,
   input logic               reg_rd,
   input logic               reg_wr,
   input logic [IDXW-1:0]    reg_idx,
   input logic               half_q,
   input logic               armed_q,
   input logic               anomaly,
   input logic               mode_active,
   input logic [DW-1:0]      reg_rdata,
   input logic [NREG*CW-1:0] rd_cfg,
   input logic [NREG*CW-1:0] wr_cfg
);

   localparam logic [IDXW:0] NREG_L = NREG[IDXW:0];

   logic ctl_go;
   logic in_range;
   logic reg_any;
   assign ctl_go   = ctl_rd | ctl_wr;
   assign in_range = {1'b0, reg_idx} < NREG_L;
   assign reg_any  = (reg_rd | reg_wr) && !ctl_go;

   p_half_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_go |=> (half_q != $past(half_q)));

   p_arm_on_lower_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_go && half_q) |=> armed_q);

   p_disarm_on_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_any && in_range && armed_q) |=> !armed_q);

   p_anomaly_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      anomaly |-> $past(ctl_go && half_q && armed_q));

   p_anomaly_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (anomaly && !(ctl_go && half_q && armed_q)) |=> !anomaly);

   p_prog_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_active |-> (reg_rdata == '0));

   p_ignore_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_any && !in_range) |=> ($stable(armed_q) && $stable(rd_cfg) && $stable(wr_cfg)));

   p_ctl_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_go |=> ($stable(rd_cfg) && $stable(wr_cfg)));

endmodule

bind macc_cfg_latch macc_cfg_latch_chk #(.DW(DW), .NREG(NREG), .IDXW(IDXW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_rd      (ctl_rd),
   .ctl_wr      (ctl_wr),
   .reg_rd      (reg_rd),
   .reg_wr      (reg_wr),
   .reg_idx     (reg_idx),
   .half_q      (half_q),
   .armed_q     (armed_q),
   .anomaly     (anomaly),
   .mode_active (mode_active),
   .reg_rdata   (reg_rdata),
   .rd_cfg      (rd_cfg),
   .wr_cfg      (wr_cfg)
);

// File: tb/tb_macc_cfg_latch.sv
module tb_macc_cfg_latch;

   localparam int NR = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_rd = 1'b0, ctl_wr = 1'b0;
   logic [15:0]   ctl_wdata = '0;
   logic [15:0]   ctl_rdata;
   logic          reg_rd = 1'b0, reg_wr = 1'b0;
   logic [2:0]    reg_idx = '0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic          mode_active, anomaly;
   logic [NR*32-1:0] rd_cfg, wr_cfg;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // reference state derived from the requirements
   logic [15:0] m_hi = '0, m_lo = '0;
   bit          m_half = 1'b0, m_armed = 1'b0, m_anom = 1'b0;
   logic [31:0] m_rd [NR];
   logic [31:0] m_wr [NR];
   logic [15:0] m_plain [NR];

   always #4 clk = ~clk;

   macc_cfg_latch dut (
      .clk(clk), .rst_n(rst_n),
      .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .mode_active(mode_active), .anomaly(anomaly),
      .rd_cfg(rd_cfg), .wr_cfg(wr_cfg)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic chk_slots(input string tag);
      for (int i = 0; i < NR; i++) begin
         chk(tag, $sformatf("rd slot %0d", i), rd_cfg[i*32 +: 32], m_rd[i]);
         chk(tag, $sformatf("wr slot %0d", i), wr_cfg[i*32 +: 32], m_wr[i]);
      end
   endtask

   // one access cycle: predict, drive, compare, update reference
   task automatic step(input bit cr, input bit cw, input bit rr, input bit rw,
                       input logic [2:0] idx, input logic [15:0] d, input string tag);
      logic [15:0] e_ctl, e_reg;
      bit e_mode;
      e_ctl  = m_half ? m_lo : m_hi;
      e_reg  = '0;
      e_mode = 1'b0;
      @(negedge clk);
      ctl_rd = cr; ctl_wr = cw; ctl_wdata = d;
      reg_rd = rr; reg_wr = rw; reg_idx = idx; reg_wdata = d;
      if (cr || cw) begin
         if (!m_half) begin
            if (cw) m_hi = d;
            m_half = 1'b1;
            m_anom = 1'b0;
         end else begin
            if (cw) m_lo = d;
            m_half = 1'b0;
            m_anom = m_armed;
            m_armed = 1'b1;
         end
      end else begin
         m_anom = 1'b0;
         if ((rr || rw) && idx < NR) begin
            if (m_armed) begin
               if (rw) m_wr[idx] = {m_hi, m_lo};
               else    m_rd[idx] = {m_hi, m_lo};
               m_armed = 1'b0;
            end else if (rw ? (m_wr[idx] != 0) : (m_rd[idx] != 0)) begin
               e_mode = 1'b1;
            end else if (rw) begin
               m_plain[idx] = d;
            end else begin
               e_reg = m_plain[idx];
            end
         end
      end
      #1;
      chk(tag, "ctl_rdata", 32'(ctl_rdata), 32'(e_ctl));
      chk(tag, "reg_rdata", 32'(reg_rdata), 32'(e_reg));
      chk(tag, "mode_active", 32'(mode_active), 32'(e_mode));
      @(posedge clk);
      #1;
      ctl_rd = 1'b0; ctl_wr = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0;
      chk(tag, "anomaly", 32'(anomaly), 32'(m_anom));
      chk_slots(tag);
   endtask

   task automatic report();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         report();
      end
   end

   initial begin
      for (int i = 0; i < NR; i++) begin
         m_rd[i] = '0; m_wr[i] = '0; m_plain[i] = '0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", "anomaly", 32'(anomaly), 0);
      chk("R1", "ctl_rdata", 32'(ctl_rdata), 0);
      chk("R1", "mode_active", 32'(mode_active), 0);
      chk_slots("R1");

      // R8 plain path on every index
      for (int i = 0; i < NR; i++) step(0, 0, 0, 1, 3'(i), 16'h1111 * 16'(i + 1), "R8");
      for (int i = 0; i < NR; i++) step(0, 0, 1, 0, 3'(i), 16'h0, "R8");

      // R10 control strobe beats register strobe; write beats read
      step(0, 1, 0, 1, 3'd0, 16'hDEAD, "R10");
      step(0, 0, 1, 0, 3'd0, 16'h0, "R10");
      step(0, 1, 0, 0, 3'd0, 16'h0001, "R2");
      step(0, 0, 1, 1, 3'd1, 16'h5A5A, "R10");
      step(0, 0, 1, 0, 3'd1, 16'h0, "R11");
      step(0, 0, 1, 1, 3'd1, 16'h7777, "R7");

      // main sweep: every index, both directions
      for (int n = 0; n < NR; n++) begin
         step(0, 1, 0, 0, 3'd0, {8'hC0 + 8'(n), 8'h5A}, "R2");
         step(0, 1, 0, 0, 3'd0, 16'h0800 + 16'h0101 * 16'(n), "R2");
         step(0, 0, 0, 1, 3'(n), 16'hFFFF, "R5");
         step(0, 0, 1, 0, 3'(n), 16'h0, "R11");
         step(0, 0, 0, 1, 3'(n), 16'hBEEF, "R7");
         step(0, 0, 1, 0, 3'(n), 16'h0, "R8");
         step(0, 1, 0, 0, 3'd0, {8'h30 + 8'(n), 8'hA5}, "R2");
         step(1, 0, 0, 0, 3'd0, 16'h0, "R3");
         step(0, 0, 1, 0, 3'(n), 16'h0, "R4");
         step(0, 0, 1, 0, 3'(n), 16'h0, "R7");
      end

      // R3 two control reads re-arm with the held word
      step(1, 0, 0, 0, 3'd0, 16'h0, "R3");
      step(1, 0, 0, 0, 3'd0, 16'h0, "R3");
      step(0, 0, 0, 1, 3'd4, 16'h0, "R4");

      // R9 out-of-range indices while armed
      step(0, 1, 0, 0, 3'd0, 16'h9ABC, "R2");
      step(0, 1, 0, 0, 3'd0, 16'h4321, "R2");
      step(0, 0, 1, 0, 3'd5, 16'h0, "R9");
      step(0, 0, 0, 1, 3'd7, 16'h1234, "R9");
      step(0, 0, 1, 1, 3'd6, 16'h5678, "R9");
      step(0, 0, 1, 0, 3'd0, 16'h0, "R9");

      // R6 a second word completed before the first was used
      step(0, 1, 0, 0, 3'd0, 16'h1357, "R6");
      step(0, 1, 0, 0, 3'd0, 16'h2468, "R6");
      step(0, 1, 0, 0, 3'd0, 16'hFACE, "R6");
      step(0, 1, 0, 0, 3'd0, 16'hCAFE, "R6");
      step(0, 0, 0, 0, 3'd0, 16'h0, "R6");
      step(0, 0, 0, 1, 3'd2, 16'h0, "R6");
      step(1, 0, 0, 0, 3'd0, 16'h0, "R6");
      step(1, 0, 0, 0, 3'd0, 16'h0, "R6");
      step(1, 0, 0, 0, 3'd0, 16'h0, "R6");
      step(0, 1, 0, 0, 3'd0, 16'h0F0F, "R6");
      step(0, 0, 1, 0, 3'd3, 16'h0, "R4");

      finished = 1'b1;
      report();
   end

endmodule